// File: doc/BRIEF.md
# Block Write Mask Unit

This unit sits on the write side of a two-bank graphics memory row buffer. It holds two 32-bit fill colors and a 32-bit per-bit write mask. The controller loads all three with a special-mode load command, and the address bits of that command pick the target. Each write command is turned into one registered write descriptor. The descriptor gives a starting column, a set of enabled columns, the data word and a 32-bit bit-enable mask. The array behind the unit applies the descriptor unchanged.

A normal write updates one column with the data lines. A block write updates up to eight aligned columns with a fill color. For a block write, the low eight data lines say which of the eight columns take part. The byte masks always clear whole bytes of the bit-enable. The per-bit mask is used only in a bank whose row was opened with the masked activate command.

Each bank has a small row state machine with three states:
- `ROW_CLOSED` goes to `ROW_MASKED` on a masked activate, or to `ROW_PLAIN` on a plain activate.
- `ROW_PLAIN` and `ROW_MASKED` go back to `ROW_CLOSED` on a precharge of that bank or on precharge-all.
- Another activate moves an open row between `ROW_PLAIN` and `ROW_MASKED`.

Writes to a bank in `ROW_CLOSED` are dropped.

Top module: `wbm_unit`

## Requirements
- R1: The command on `cmd_i` is coded as 0 no-op, 1 activate, 2 masked activate, 3 precharge, 4 write, 5 block write, 6 special-mode load, 7 precharge-all. While reset is held, and after it is released, `wr_valid_o` and `lsmr_err_o` are 0. Whenever `wr_valid_o` is 0, `wr_col_en_o` and `wr_bit_en_o` are 0. After reset all three registers are zero and both banks are closed.
- R2: A special-mode load with `addr_i` equal to 0x040 loads color 0 from `dq_i`. In one-color mode (`two_color_i` = 0), bit 7 is ignored, so 0x0C0 also loads color 0.
- R3: A special-mode load with `addr_i` equal to 0x0C0 loads color 1, but only when `two_color_i` is 1. Color 1 is never loaded in one-color mode.
- R4: A special-mode load with `addr_i` equal to 0x020 loads the per-bit mask register from `dq_i`. Any address with other bits set loads nothing.
- R5: A special-mode load with address bit 5 set together with bit 6 or bit 7 loads no register. `lsmr_err_o` is high for exactly the one cycle after that command.
- R6: A write (code 4) to an open bank produces, one cycle later, `wr_valid_o`=1 and `wr_block_o`=0, with `wr_col_o` = `addr_i[7:0]`, `wr_col_en_o` = 0x01 and `wr_data_o` = `dq_i`.
- R7: A block write (code 5) to an open bank produces, one cycle later, `wr_block_o`=1 and `wr_col_o` = {`addr_i[7:3]`,000}. `wr_col_en_o` = `dq_i[7:0]`, where bit i enables column i of the group. `wr_data_o` is color 1 when `two_color_i` and `addr_i[0]` are both 1, and color 0 otherwise.
- R8: `dqm_i[k]` high clears bits 8k+7..8k of `wr_bit_en_o`, whether or not the per-bit mask is in use.
- R9: In a bank opened by masked activate, `wr_bit_en_o` is additionally ANDed with the mask register. Otherwise all bits not cleared by the byte masks are set. A plain activate, a precharge of the bank or precharge-all clears the masked state.
- R10: A write or block write to a bank with no open row produces no descriptor.
- R11: Color and mask registers keep their values through all other commands until they are reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code |
| bank_i | input | 1 | Bank select |
| addr_i | input | 10 | Address / special-mode selector |
| dq_i | input | 32 | Data lines (write data, register data, column mask) |
| dqm_i | input | 4 | Byte masks, 1 = byte not written |
| two_color_i | input | 1 | Two-color mode enable |
| wr_valid_o | output | 1 | Write descriptor valid |
| wr_block_o | output | 1 | Descriptor is a block write |
| wr_col_o | output | 8 | Starting column |
| wr_col_en_o | output | 8 | Column enables relative to the starting column |
| wr_data_o | output | 32 | Data or fill color |
| wr_bit_en_o | output | 32 | Per-bit write enables |
| lsmr_err_o | output | 1 | Illegal special-mode load seen |

## Verification
Two functions can fall on the same write: the byte masks and the per-bit mask register. Both shape the bit-enable of that one descriptor. The bench opens a masked row, loads a mask pattern, and issues writes with nonzero byte masks. The expected bit-enable is the AND of the inverted byte mask and the mask register. The same writes are also sent to the plain bank, where only the byte masks should apply. The fill color chosen for a block write relies on register loads made in earlier cycles. It is judged after mode changes and after an illegal load, which must leave the colors and the mask as they were.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_ACT    = 3'd1,
        CMD_ACTM   = 3'd2,
        CMD_PRE    = 3'd3,
        CMD_WR     = 3'd4,
        CMD_BW     = 3'd5,
        CMD_LSMR   = 3'd6,
        CMD_PREALL = 3'd7
    } wbm_cmd_e;

    typedef enum logic [1:0] {
        ROW_CLOSED = 2'd0,
        ROW_PLAIN  = 2'd1,
        ROW_MASKED = 2'd2
    } row_state_e;
endpackage

// File: rtl/wbm_special_regs.sv
module wbm_special_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              two_color_i,
    output logic [DATA_W-1:0] color0_o,
    output logic [DATA_W-1:0] color1_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              err_o
);
    localparam int SEL_MASK = 5;
    localparam int SEL_COL  = 6;
    localparam int SEL_HI   = 7;
    localparam logic [ADDR_W-1:0] SEL_BITS =
        ADDR_W'((1 << SEL_MASK) | (1 << SEL_COL) | (1 << SEL_HI));

    logic rest_zero, hit_mask, hit_c0, hit_c1, illegal;

    always_comb begin
        rest_zero = (addr_i & ~SEL_BITS) == '0;
        illegal   = load_i && addr_i[SEL_MASK] && (addr_i[SEL_COL] || addr_i[SEL_HI]);
        hit_mask  = load_i && rest_zero && addr_i[SEL_MASK]
                    && !addr_i[SEL_COL] && !addr_i[SEL_HI];
        hit_c0    = load_i && rest_zero && !addr_i[SEL_MASK] && addr_i[SEL_COL]
                    && (!addr_i[SEL_HI] || !two_color_i);
        hit_c1    = load_i && rest_zero && !addr_i[SEL_MASK] && addr_i[SEL_COL]
                    && addr_i[SEL_HI] && two_color_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            color0_o <= '0;
            color1_o <= '0;
            mask_o   <= '0;
            err_o    <= 1'b0;
        end else begin
            err_o <= illegal;
            if (hit_c0)   color0_o <= data_i;
            if (hit_c1)   color1_o <= data_i;
            if (hit_mask) mask_o   <= data_i;
        end
    end
endmodule

// File: rtl/wbm_row_fsm.sv
module wbm_row_fsm
    import wbm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic open_plain_i,
    input  logic open_masked_i,
    input  logic close_i,
    output logic open_o,
    output logic masked_o
);
    row_state_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= ROW_CLOSED;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ROW_CLOSED: begin
                if (open_masked_i)     st_d = ROW_MASKED;
                else if (open_plain_i) st_d = ROW_PLAIN;
            end
            ROW_PLAIN, ROW_MASKED: begin
                if (close_i)            st_d = ROW_CLOSED;
                else if (open_masked_i) st_d = ROW_MASKED;
                else if (open_plain_i)  st_d = ROW_PLAIN;
            end
            default: st_d = ROW_CLOSED;
        endcase
    end

    always_comb begin
        open_o   = (st_q != ROW_CLOSED);
        masked_o = (st_q == ROW_MASKED);
    end
endmodule

// File: rtl/wbm_write_gen.sv
module wbm_write_gen #(
    parameter int DATA_W = 32,
    parameter int COL_W  = 8,
    parameter int GRP    = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic                 bw_i,
    input  logic                 open_i,
    input  logic                 masked_i,
    input  logic [COL_W-1:0]     col_i,
    input  logic [DATA_W-1:0]    data_i,
    input  logic [DATA_W/8-1:0]  dqm_i,
    input  logic                 two_color_i,
    input  logic [DATA_W-1:0]    color0_i,
    input  logic [DATA_W-1:0]    color1_i,
    input  logic [DATA_W-1:0]    mask_i,
    output logic                 valid_o,
    output logic                 block_o,
    output logic [COL_W-1:0]     col_o,
    output logic [GRP-1:0]       col_en_o,
    output logic [DATA_W-1:0]    data_o,
    output logic [DATA_W-1:0]    bit_en_o
);
    localparam int NBYTES  = DATA_W / 8;
    localparam int GRP_LSB = $clog2(GRP);

    logic [DATA_W-1:0] byte_keep;
    logic [DATA_W-1:0] bit_en_d;
    logic              go;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign byte_keep[8*k +: 8] = {8{~dqm_i[k]}};
    end

    always_comb begin
        go       = (wr_i || bw_i) && open_i;
        bit_en_d = byte_keep & (masked_i ? mask_i : {DATA_W{1'b1}});
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_o  <= 1'b0;
            block_o  <= 1'b0;
            col_o    <= '0;
            col_en_o <= '0;
            data_o   <= '0;
            bit_en_o <= '0;
        end else begin
            valid_o <= go;
            block_o <= go && bw_i;
            if (!go) begin
                col_en_o <= '0;
                bit_en_o <= '0;
            end else if (bw_i) begin
                col_o    <= {col_i[COL_W-1:GRP_LSB], {GRP_LSB{1'b0}}};
                col_en_o <= data_i[GRP-1:0];
                data_o   <= (two_color_i && col_i[0]) ? color1_i : color0_i;
                bit_en_o <= bit_en_d;
            end else begin
                col_o    <= col_i;
                col_en_o <= GRP'(1);
                data_o   <= data_i;
                bit_en_o <= bit_en_d;
            end
        end
    end
endmodule

// File: rtl/wbm_unit.sv
module wbm_unit
    import wbm_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int COL_W     = 8,
    parameter int GRP       = 8,
    parameter int NUM_BANKS = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int NBYTES   = DATA_W / 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] dq_i,
    input  logic [NBYTES-1:0] dqm_i,
    input  logic              two_color_i,
    output logic              wr_valid_o,
    output logic              wr_block_o,
    output logic [COL_W-1:0]  wr_col_o,
    output logic [GRP-1:0]    wr_col_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] wr_bit_en_o,
    output logic              lsmr_err_o
);
    wbm_cmd_e cmd;
    assign cmd = wbm_cmd_e'(cmd_i);

    logic [DATA_W-1:0]    color0, color1, mask;
    logic [NUM_BANKS-1:0] bank_open, bank_masked;

    wbm_special_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (cmd == CMD_LSMR),
        .addr_i      (addr_i),
        .data_i      (dq_i),
        .two_color_i (two_color_i),
        .color0_o    (color0),
        .color1_o    (color1),
        .mask_o      (mask),
        .err_o       (lsmr_err_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (bank_i == BANK_W'(b));
        wbm_row_fsm i_row (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .open_plain_i  (sel && cmd == CMD_ACT),
            .open_masked_i (sel && cmd == CMD_ACTM),
            .close_i       ((sel && cmd == CMD_PRE) || cmd == CMD_PREALL),
            .open_o        (bank_open[b]),
            .masked_o      (bank_masked[b])
        );
    end

    wbm_write_gen #(.DATA_W(DATA_W), .COL_W(COL_W), .GRP(GRP)) i_wgen (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (cmd == CMD_WR),
        .bw_i        (cmd == CMD_BW),
        .open_i      (bank_open[bank_i]),
        .masked_i    (bank_masked[bank_i]),
        .col_i       (addr_i[COL_W-1:0]),
        .data_i      (dq_i),
        .dqm_i       (dqm_i),
        .two_color_i (two_color_i),
        .color0_i    (color0),
        .color1_i    (color1),
        .mask_i      (mask),
        .valid_o     (wr_valid_o),
        .block_o     (wr_block_o),
        .col_o       (wr_col_o),
        .col_en_o    (wr_col_en_o),
        .data_o      (wr_data_o),
        .bit_en_o    (wr_bit_en_o)
    );
endmodule

// File: rtl/wbm_unit_chk.sv
module wbm_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int COL_W  = 8,
    parameter int GRP    = 8,
    localparam int NBYTES  = DATA_W / 8,
    localparam int GRP_LSB = $clog2(GRP)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [2:0]        cmd_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [NBYTES-1:0] dqm_i,
    input logic              wr_valid_o,
    input logic              wr_block_o,
    input logic [COL_W-1:0]  wr_col_o,
    input logic [GRP-1:0]    wr_col_en_o,
    input logic [DATA_W-1:0] wr_bit_en_o,
    input logic              lsmr_err_o
);
    logic [DATA_W-1:0] dqm_bits;
    for (genvar k = 0; k < NBYTES; k++) begin : g_exp
        assign dqm_bits[8*k +: 8] = {8{dqm_i[k]}};
    end

    p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_valid_o |-> (wr_col_en_o == '0 && wr_bit_en_o == '0));

    p_err_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsmr_err_o |-> $past(cmd_i == 3'd6 && addr_i[5] && (addr_i[6] || addr_i[7])));

    p_err_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsmr_err_o |-> !wr_valid_o);

    p_write_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> ($past(cmd_i) == 3'd4 || $past(cmd_i) == 3'd5));

    p_single_col_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && !wr_block_o) |-> wr_col_en_o == GRP'(1));

    p_block_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && wr_block_o) |-> wr_col_o[GRP_LSB-1:0] == '0);

    p_bytemask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> (wr_bit_en_o & $past(dqm_bits)) == '0);
endmodule

bind wbm_unit wbm_unit_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .GRP    (GRP)
) i_wbm_unit_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .addr_i      (addr_i),
    .dqm_i       (dqm_i),
    .wr_valid_o  (wr_valid_o),
    .wr_block_o  (wr_block_o),
    .wr_col_o    (wr_col_o),
    .wr_col_en_o (wr_col_en_o),
    .wr_bit_en_o (wr_bit_en_o),
    .lsmr_err_o  (lsmr_err_o)
);

// File: tb/test_wbm_unit.sv
`timescale 1ns/1ps
module test_wbm_unit;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, ACTM = 3'd2, PRE = 3'd3,
                           WR = 3'd4, BW = 3'd5, LSMR = 3'd6, PREALL = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = NOP;
    logic        bank = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] dq = '0;
    logic [3:0]  dqm = '0;
    logic        two_color = 1'b0;
    logic        wr_valid, wr_block, lsmr_err;
    logic [7:0]  wr_col, wr_col_en;
    logic [31:0] wr_data, wr_bit_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wbm_unit i_wbm_unit (
        .clk_i (clk), .rst_ni (rst_n), .cmd_i (cmd), .bank_i (bank),
        .addr_i (addr), .dq_i (dq), .dqm_i (dqm), .two_color_i (two_color),
        .wr_valid_o (wr_valid), .wr_block_o (wr_block), .wr_col_o (wr_col),
        .wr_col_en_o (wr_col_en), .wr_data_o (wr_data),
        .wr_bit_en_o (wr_bit_en), .lsmr_err_o (lsmr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge; returns one falling edge later,
    // when the registered result of that command is visible.
    task automatic issue(input logic [2:0] c, input logic b, input logic [9:0] a,
                         input logic [31:0] d, input logic [3:0] m);
        cmd = c; bank = b; addr = a; dq = d; dqm = m;
        @(negedge clk);
        cmd = NOP; bank = 1'b0; addr = '0; dq = '0; dqm = '0;
    endtask

    task automatic t_reset;
        chk("R1 valid", {31'd0, wr_valid}, 32'd0);
        chk("R1 err", {31'd0, lsmr_err}, 32'd0);
        chk("R1 bit_en", wr_bit_en, 32'd0);
        issue(WR, 1'b0, 10'h005, 32'h1234_5678, 4'h0);
        chk("R1 bank closed after reset", {31'd0, wr_valid}, 32'd0);
        issue(ACT, 1'b0, 10'h000, 32'd0, 4'h0);
        issue(BW, 1'b0, 10'h000, 32'h0000_00FF, 4'h0);
        chk("R1 color0 zero after reset", wr_data, 32'd0);
        issue(PREALL, 1'b0, 10'h000, 32'd0, 4'h0);
    endtask

    task automatic t_colors;
        two_color = 1'b1;
        issue(LSMR, 1'b0, 10'h040, 32'hA5A5_0001, 4'h0);
        issue(LSMR, 1'b0, 10'h0C0, 32'h5A5A_0002, 4'h0);
        issue(ACT, 1'b0, 10'h000, 32'd0, 4'h0);
        issue(BW, 1'b0, 10'h001, 32'h0000_00FF, 4'h0);
        chk("R7 block flag", {31'd0, wr_block}, 32'd1);
        chk("R3 color1 via A0", wr_data, 32'h5A5A_0002);
        chk("R7 base col", {24'd0, wr_col}, 32'h00);
        chk("R7 col en", {24'd0, wr_col_en}, 32'hFF);
        issue(BW, 1'b0, 10'h02A, 32'hFFFF_FF3C, 4'h0);
        chk("R2 color0 via A0=0", wr_data, 32'hA5A5_0001);
        chk("R7 aligned col", {24'd0, wr_col}, 32'h28);
        chk("R7 col mask from dq", {24'd0, wr_col_en}, 32'h3C);
        chk("R7 bit_en plain row", wr_bit_en, 32'hFFFF_FFFF);
    endtask

    task automatic t_one_color;
        two_color = 1'b0;
        issue(LSMR, 1'b0, 10'h0C0, 32'h1111_2222, 4'h0);
        issue(BW, 1'b0, 10'h001, 32'h0000_0001, 4'h0);
        chk("R2 one-color A7 ignored, A0 ignored", wr_data, 32'h1111_2222);
        two_color = 1'b1;
        issue(BW, 1'b0, 10'h001, 32'h0000_0001, 4'h0);
        chk("R3 color1 untouched in one-color R11", wr_data, 32'h5A5A_0002);
    endtask

    task automatic t_masks;
        issue(LSMR, 1'b0, 10'h020, 32'h0F0F_00FF, 4'h0);
        issue(ACTM, 1'b1, 10'h000, 32'd0, 4'h0);
        issue(WR, 1'b1, 10'h013, 32'hDEAD_BEEF, 4'h0);
        chk("R6 valid", {31'd0, wr_valid}, 32'd1);
        chk("R6 not block", {31'd0, wr_block}, 32'd0);
        chk("R6 col", {24'd0, wr_col}, 32'h13);
        chk("R6 col en", {24'd0, wr_col_en}, 32'h01);
        chk("R6 data", wr_data, 32'hDEAD_BEEF);
        chk("R4 R9 masked row uses mask", wr_bit_en, 32'h0F0F_00FF);
        issue(WR, 1'b0, 10'h013, 32'hDEAD_BEEF, 4'h0);
        chk("R9 plain bank ignores mask", wr_bit_en, 32'hFFFF_FFFF);
        issue(WR, 1'b1, 10'h013, 32'h0, 4'b0001);
        chk("R8 byte mask with per-bit mask", wr_bit_en, 32'h0F0F_0000);
        issue(WR, 1'b0, 10'h013, 32'h0, 4'b1010);
        chk("R8 byte mask plain row", wr_bit_en, 32'h00FF_00FF);
        issue(BW, 1'b1, 10'h0F8, 32'h0000_0081, 4'b0100);
        chk("R8 R9 block write masking", wr_bit_en, 32'h0F00_00FF);
        issue(PRE, 1'b1, 10'h000, 32'd0, 4'h0);
        issue(WR, 1'b1, 10'h013, 32'h0, 4'h0);
        chk("R10 write after precharge dropped", {31'd0, wr_valid}, 32'd0);
        issue(ACT, 1'b1, 10'h000, 32'd0, 4'h0);
        issue(WR, 1'b1, 10'h013, 32'h0, 4'h0);
        chk("R9 plain activate clears masked state", wr_bit_en, 32'hFFFF_FFFF);
        issue(ACTM, 1'b1, 10'h000, 32'd0, 4'h0);
        issue(PREALL, 1'b0, 10'h000, 32'd0, 4'h0);
        issue(WR, 1'b1, 10'h013, 32'h0, 4'h0);
        chk("R10 bank1 closed by precharge-all", {31'd0, wr_valid}, 32'd0);
        issue(BW, 1'b0, 10'h000, 32'h0000_00FF, 4'h0);
        chk("R10 bank0 closed by precharge-all", {31'd0, wr_valid}, 32'd0);
        issue(ACTM, 1'b1, 10'h000, 32'd0, 4'h0);
        issue(ACT, 1'b1, 10'h000, 32'd0, 4'h0);
        issue(WR, 1'b1, 10'h013, 32'h0, 4'h0);
        chk("R9 re-activate plain clears mask use", wr_bit_en, 32'hFFFF_FFFF);
        issue(PREALL, 1'b0, 10'h000, 32'd0, 4'h0);
    endtask

    task automatic t_illegal;
        issue(LSMR, 1'b0, 10'h060, 32'hFFFF_FFFF, 4'h0);
        chk("R5 err pulse", {31'd0, lsmr_err}, 32'd1);
        issue(LSMR, 1'b0, 10'h0A0, 32'hFFFF_FFFF, 4'h0);
        chk("R5 err with A5+A7", {31'd0, lsmr_err}, 32'd1);
        issue(NOP, 1'b0, 10'h000, 32'd0, 4'h0);
        chk("R5 err one cycle only", {31'd0, lsmr_err}, 32'd0);
        issue(LSMR, 1'b0, 10'h041, 32'hFFFF_FFFF, 4'h0);
        chk("R4 extra address bit no err", {31'd0, lsmr_err}, 32'd0);
        issue(LSMR, 1'b0, 10'h080, 32'hFFFF_FFFF, 4'h0);
        issue(ACTM, 1'b0, 10'h000, 32'd0, 4'h0);
        issue(BW, 1'b0, 10'h000, 32'h0000_0001, 4'h0);
        chk("R5 R11 color0 kept", wr_data, 32'h1111_2222);
        chk("R5 R11 mask kept", wr_bit_en, 32'h0F0F_00FF);
        issue(BW, 1'b0, 10'h001, 32'h0000_0001, 4'h0);
        chk("R11 color1 kept", wr_data, 32'h5A5A_0002);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, wr_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_colors();
        t_one_color();
        t_masks();
        t_illegal();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule